// File: doc/BRIEF.md
# Counter-Based Hysteresis Input Filter

This block turns a noisy single-bit level into a clean one. A signed up/down counter moves one step up for every enabled sample at 1 and one step down for every sample at 0. At the end of each programmable filter period the counter is halved with its sign kept. Old history therefore fades away, and the counter cannot grow without bound.

The output changes level only when the counter crosses a programmable switching level in the direction opposite to the current output: above +level to go high, below -level to go low. This gives hysteresis. Larger periods reject longer glitches but respond more slowly, and a larger level widens the dead band. For sensible behaviour the level should be kept below twice the period.

All state advances only on cycles where the enable is high, so a slow sampling rate can be set without a second clock. The input is expected to be synchronous already.

Top module: `hyst_filter`

## Requirements
- R1: While rst_ni is low, dout_o is 0. After reset is released, the counter and the period counter start from 0, so a fresh run behaves exactly as one from power-up.
- R2: On each enabled cycle that does not end a period, the difference counter increases by 1 when din_i is 1 and decreases by 1 when din_i is 0.
- R3: A period counter counts enabled cycles from 0 up to period_i. On the enabled cycle where it equals period_i, it returns to 0, and the difference counter is loaded with (difference ±1) arithmetically shifted right by one place, which keeps the sign and rounds toward minus infinity.
- R4: While dout_o is 0, it becomes 1 on the enabled cycle where the updated difference is strictly greater than level_i. Equality does not switch the output.
- R5: While dout_o is 1, it becomes 0 on the enabled cycle where the updated difference is strictly less than -level_i. Equality does not switch the output.
- R6: With en_i low, the difference counter, the period counter and dout_o all hold their values, whatever din_i does.
- R7: With period_i equal to 0, halving takes place on every enabled cycle.
- R8: The difference counter is CFG_W+2 bits signed and saturates at its limits, so it never wraps and never changes sign through overflow.
- R9: The threshold comparison uses the value the counter takes in the same enabled cycle, after any halving. The output changes on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable; state advances only when high |
| din_i | input | 1 | Raw input level |
| period_i | input | CFG_W | Filter period in enabled cycles, unsigned |
| level_i | input | CFG_W | Switching level, unsigned |
| dout_o | output | 1 | Filtered output level |

## Verification
The halving at the end of a period and the threshold decision can fall on the same enabled cycle. At that point the step that would have crossed the level is halved first, so the output must not switch. The bench sets up this case with a period of 2 and a level of 2. Three high samples put the third sample exactly on the wrap, and the output is expected to stay 0. Two more samples are then needed before it rises. A falling run with a period of 3 also lands a halving on a negative value, which checks that the shift rounds toward minus infinity.

// File: rtl/hyst_pkg.sv
package hyst_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CFG_W_DEF = 16;

  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } lvl_e;
endpackage

// File: rtl/hyst_period_timer.sv
module hyst_period_timer #(
  parameter int unsigned CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] period_i,
  output logic             wrap_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [CFG_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i) begin
      if (wrap_o)    cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && wrap_o |=> cnt_q == '0);

  assert_hold_cnt_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/hyst_diff_acc.sv
module hyst_diff_acc #(
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned DIFF_W = CFG_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     din_i,
  input  logic                     wrap_i,
  output logic signed [DIFF_W-1:0] diff_next_o,
  output logic signed [DIFF_W-1:0] diff_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic signed [DIFF_W-1:0] D_MAX = {1'b0, {(DIFF_W-1){1'b1}}};
  localparam logic signed [DIFF_W-1:0] D_MIN = {1'b1, {(DIFF_W-1){1'b0}}};
  localparam logic signed [DIFF_W-1:0] ONE   = {{(DIFF_W-1){1'b0}}, 1'b1};

  logic signed [DIFF_W-1:0] diff_q;
  logic signed [DIFF_W-1:0] step;

  always_comb begin
    if (din_i) step = (diff_q == D_MAX) ? diff_q : diff_q + ONE;
    else       step = (diff_q == D_MIN) ? diff_q : diff_q - ONE;
    diff_next_o = wrap_i ? (step >>> 1) : step;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   diff_q <= '0;
    else if (en_i) diff_q <= diff_next_o;
  end

  assign diff_o = diff_q;

  assert_step_up_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !wrap_i && din_i && diff_q != D_MAX |=> diff_q == $past(diff_q) + ONE);

  assert_step_dn_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !wrap_i && !din_i && diff_q != D_MIN |=> diff_q == $past(diff_q) - ONE);

  assert_halve_shrinks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && wrap_i && !din_i && !diff_q[DIFF_W-1] |=> diff_q <= $past(diff_q));

  assert_no_overflow_pos_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && din_i && !diff_q[DIFF_W-1] |=> !diff_q[DIFF_W-1]);

  assert_no_overflow_neg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !din_i && diff_q[DIFF_W-1] |=> diff_q[DIFF_W-1]);

  assert_hold_diff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(diff_q));
endmodule

// File: rtl/hyst_level_decide.sv
module hyst_level_decide
  import hyst_pkg::*;
#(
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned DIFF_W = CFG_W + 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic signed [DIFF_W-1:0] diff_next_i,
  input  logic signed [DIFF_W-1:0] diff_i,
  input  logic [CFG_W-1:0]         level_i,
  output logic                     dout_o
);
  timeunit 1ns;
  timeprecision 1ps;

  lvl_e state_q, state_d;
  logic signed [DIFF_W-1:0] lvl_pos, lvl_neg;

  assign lvl_pos = $signed({2'b00, level_i});
  assign lvl_neg = -lvl_pos;

  // decision on the value being written this cycle
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LVL_LOW:  if (diff_next_i > lvl_pos) state_d = LVL_HIGH;
      LVL_HIGH: if (diff_next_i < lvl_neg) state_d = LVL_LOW;
      default:  state_d = LVL_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= LVL_LOW;
    else if (en_i) state_q <= state_d;
  end

  assign dout_o = (state_q == LVL_HIGH);

  assert_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_o) |-> diff_i > lvl_pos);

  assert_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dout_o) |-> diff_i < lvl_neg);

  assert_hold_out_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(dout_o));
endmodule

// File: rtl/hyst_filter.sv
module hyst_filter #(
  parameter int unsigned CFG_W = hyst_pkg::CFG_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             din_i,
  input  logic [CFG_W-1:0] period_i,
  input  logic [CFG_W-1:0] level_i,
  output logic             dout_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned DIFF_W = CFG_W + 2;

  logic                     wrap;
  logic signed [DIFF_W-1:0] diff_next, diff;

  hyst_period_timer #(.CFG_W(CFG_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period_i),
    .wrap_o   (wrap)
  );

  hyst_diff_acc #(.CFG_W(CFG_W), .DIFF_W(DIFF_W)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .din_i       (din_i),
    .wrap_i      (wrap),
    .diff_next_o (diff_next),
    .diff_o      (diff)
  );

  hyst_level_decide #(.CFG_W(CFG_W), .DIFF_W(DIFF_W)) u_decide (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .diff_next_i (diff_next),
    .diff_i      (diff),
    .level_i     (level_i),
    .dout_o      (dout_o)
  );
endmodule

// File: tb/hyst_filter_test.sv
module hyst_filter_test;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic [15:0] per;
    logic [15:0] lvl;
    logic [7:0]  ones;
    logic [7:0]  zeros;
    logic        exp;
  } vec_t;

  // reset, then `ones` high samples, then `zeros` low samples, then expect
  localparam vec_t VECS [14] = '{
    '{16'd100, 16'd5,  8'd5,  8'd0,  1'b0},  // R4 equal to level
    '{16'd100, 16'd5,  8'd6,  8'd0,  1'b1},  // R4 one above
    '{16'd3,   16'd2,  8'd2,  8'd0,  1'b0},  // R2
    '{16'd3,   16'd2,  8'd3,  8'd0,  1'b1},  // R2
    '{16'd2,   16'd2,  8'd3,  8'd0,  1'b0},  // R9 crossing halved
    '{16'd2,   16'd2,  8'd4,  8'd0,  1'b0},  // R3
    '{16'd2,   16'd2,  8'd5,  8'd0,  1'b1},  // R3
    '{16'd0,   16'd0,  8'd10, 8'd0,  1'b0},  // R7 halved every cycle
    '{16'd1,   16'd1,  8'd2,  8'd0,  1'b0},  // R3
    '{16'd1,   16'd1,  8'd3,  8'd1 - 8'd1, 1'b1},  // R3
    '{16'd100, 16'd5,  8'd6,  8'd11, 1'b1},  // R5 equal to -level
    '{16'd100, 16'd5,  8'd6,  8'd12, 1'b0},  // R5 one below
    '{16'd3,   16'd2,  8'd3,  8'd5,  1'b1},  // R3 negative halving floors
    '{16'd3,   16'd2,  8'd3,  8'd6,  1'b0}   // R3
  };

  localparam string VREQ [14] = '{"R4", "R4", "R2", "R2", "R9", "R3", "R3",
                                  "R7", "R3", "R3", "R5", "R5", "R3", "R3"};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        din = 1'b0;
  logic [15:0] period = '0;
  logic [15:0] level = '0;
  logic [3:0]  period_n = 4'd15;
  logic [3:0]  level_n = 4'd15;
  logic        dout, dout_n;
  int          n_tests = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  hyst_filter #(.CFG_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .din_i(din),
    .period_i(period), .level_i(level), .dout_o(dout)
  );

  hyst_filter #(.CFG_W(4)) uut_narrow (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .din_i(din),
    .period_i(period_n), .level_i(level_n), .dout_o(dout_n)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic e);
    din = d;
    en  = e;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [15:0] p, input logic [15:0] l);
    @(negedge clk);
    rst_n  = 1'b0;
    en     = 1'b0;
    period = p;
    level  = l;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run hung, dout=%b expected finish", dout);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(16'd100, 16'd5);
    chk(dout, 1'b0, "R1");

    for (int i = 0; i < 14; i++) begin
      do_reset(VECS[i].per, VECS[i].lvl);
      for (int k = 0; k < int'(VECS[i].ones); k++)  step(1'b1, 1'b1);
      for (int k = 0; k < int'(VECS[i].zeros); k++) step(1'b0, 1'b1);
      chk(dout, VECS[i].exp, VREQ[i]);
    end

    // R1: reset mid-run clears output and counter
    do_reset(16'd100, 16'd5);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1);
    chk(dout, 1'b1, "R4");
    do_reset(16'd100, 16'd5);
    chk(dout, 1'b0, "R1");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1);
    chk(dout, 1'b0, "R1");

    // R6: disabled cycles leave count and output alone
    do_reset(16'd100, 16'd5);
    for (int k = 0; k < 5; k++)  step(1'b1, 1'b1);
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0);
    chk(dout, 1'b0, "R6");
    step(1'b1, 1'b1);
    chk(dout, 1'b1, "R6");
    for (int k = 0; k < 30; k++) step(1'b0, 1'b0);
    chk(dout, 1'b1, "R6");
    for (int k = 0; k < 11; k++) step(1'b0, 1'b1);
    chk(dout, 1'b1, "R6");
    step(1'b0, 1'b1);
    chk(dout, 1'b0, "R6");

    // R9: output changes on the same edge the counter crosses
    do_reset(16'd3, 16'd2);
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    chk(dout, 1'b0, "R9");
    step(1'b1, 1'b1);
    chk(dout, 1'b1, "R9");

    // R8: narrow instance, long runs at the widest period keep their sign
    do_reset(16'd100, 16'd5);
    for (int k = 0; k < 200; k++) step(1'b1, 1'b1);
    chk(dout_n, 1'b1, "R8");
    for (int k = 0; k < 200; k++) step(1'b0, 1'b1);
    chk(dout_n, 1'b0, "R8");
    for (int k = 0; k < 200; k++) step(1'b1, 1'b1);
    chk(dout_n, 1'b1, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule